// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 operands and writes a 2-bit condition code that says whether the first operand is equal to, below, above or unordered with the second. The precision select picks the format. Double precision uses the full 64-bit operand words. Single precision uses only the low 32 bits of each word.

Two compare variants exist. The quiet variant flags an invalid operation only for a signaling NaN. The signalling variant flags it for any NaN. When invalid is raised and its trap enable is set, the unit requests a trap and the condition-code register keeps its previous value. Otherwise the new code is written.

A compare is launched by a one-cycle start strobe. The code, a 5-bit current-exception field and the trap request all come from registers, and they appear one clock later together with a done pulse.

Top module: `fp_cmp_unit`

## Requirements
- R1: For ordered operands the code is 0 when they are equal, 1 when the first is less and 2 when the first is greater.
- R2: When either operand is a NaN, quiet or signaling, the code is 3 (unordered). A NaN has an all-ones exponent and a non-zero fraction. A quiet NaN has the fraction MSB at 1 and a signaling NaN has it at 0.
- R3: A signaling NaN operand sets invalid in both variants. A quiet NaN in the quiet variant (sig_cmp=0) leaves invalid clear.
- R4: In the signalling variant (sig_cmp=1) any NaN operand sets invalid.
- R5: A trap is requested exactly when invalid is set and inv_trap_en is 1. In that case cc keeps its old value. Otherwise cc takes the new code.
- R6: Positive zero and negative zero compare equal, in both precisions.
- R7: Infinities order by sign like finite values. Subnormal operands are compared exactly, with no flush to zero.
- R8: With dbl=0 the operands are the low 32 bits of each word, and bits 63:32 have no effect.
- R9: done, trap and exc_now update on the clock edge after a start strobe, and done is high only for that cycle. Without a start, done and trap stay 0 and cc holds its value.
- R10: After reset cc is 0, exc_now is 0, trap is 0 and done is 0.
- R11: exc_now bit 4 is the invalid flag. Bits 3:0 (overflow, underflow, divide-by-zero, inexact) are always 0 after a compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle compare strobe |
| dbl | input | 1 | 1 = double precision, 0 = single precision |
| sig_cmp | input | 1 | 1 = signalling variant, 0 = quiet variant |
| inv_trap_en | input | 1 | Invalid-operation trap enable |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| cc | output | 2 | Condition-code register |
| exc_now | output | 5 | Current-exception flags, bit 4 = invalid |
| trap | output | 1 | Trap request, valid with done |
| done | output | 1 | Result-valid pulse |

## Verification
The condition code lives in a register that a trap must leave alone. If that register is written by mistake, the fault shows at cc in the same cycle as done. It also shows on every later compare that expects the held value, so the bench keeps its own model of the held code. A wrong NaN or sign decode surfaces at cc or exc_now on the very pulse of the affected compare. Randomized operands mix special values, near-equal words and garbage in the unused upper half, so that such decode faults are reached.

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit #(
  parameter int DW = 64,
  parameter int DE = 11,
  parameter int SW = 32,
  parameter int SE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dbl,
  input  logic          sig_cmp,
  input  logic          inv_trap_en,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [1:0]    cc,
  output logic [4:0]    exc_now,
  output logic          trap,
  output logic          done
);
  localparam int DF = DW - 1 - DE;
  localparam int SF = SW - 1 - SE;

  function automatic logic [DW-2:0] mag_of(input logic [DW-1:0] x, input logic d);
    return d ? x[DW-2:0] : {{(DW-SW){1'b0}}, x[SW-2:0]};
  endfunction

  function automatic logic nan_of(input logic [DW-1:0] x, input logic d);
    return d ? (&x[DW-2 -: DE]) && (|x[DF-1:0]) : (&x[SW-2 -: SE]) && (|x[SF-1:0]);
  endfunction

  function automatic logic quiet_of(input logic [DW-1:0] x, input logic d);
    return d ? x[DF-1] : x[SF-1];
  endfunction

  logic          sa, sb, na, nb, qa, qb, unord, inv, lt;
  logic [DW-2:0] ma, mb;
  logic [1:0]    code;

  assign sa    = dbl ? opa[DW-1] : opa[SW-1];
  assign sb    = dbl ? opb[DW-1] : opb[SW-1];
  assign ma    = mag_of(opa, dbl);
  assign mb    = mag_of(opb, dbl);
  assign na    = nan_of(opa, dbl);
  assign nb    = nan_of(opb, dbl);
  assign qa    = quiet_of(opa, dbl);
  assign qb    = quiet_of(opb, dbl);
  assign unord = na | nb;
  assign inv   = (na & ~qa) | (nb & ~qb) | (sig_cmp & unord);
  assign lt    = ma < mb;

  always_comb begin
    if (unord)                                        code = 2'd3;
    else if ((ma == '0 && mb == '0) || (sa == sb && ma == mb)) code = 2'd0;
    else if (sa != sb)                                code = sa ? 2'd1 : 2'd2;
    else if (!sa)                                     code = lt ? 2'd1 : 2'd2;
    else                                              code = lt ? 2'd2 : 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc      <= 2'd0;
      exc_now <= 5'd0;
      trap    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= start;
      trap <= start & inv & inv_trap_en;
      if (start) begin
        exc_now <= {inv, 4'b0000};
        if (!(inv && inv_trap_en)) cc <= code;
      end
    end
  end
endmodule

module fp_cmp_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       inv_trap_en,
  input logic [1:0] cc,
  input logic [4:0] exc_now,
  input logic       trap,
  input logic       done
);
  a_r9_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r9_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));
  a_r5_cc_held_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> cc == $past(cc));
  a_r5_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> exc_now[4] && $past(inv_trap_en));
  a_r9_no_idle_trap: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !trap);
  a_r3_invalid_rises_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_now[4]) |-> done);
endmodule

bind fp_cmp_unit fp_cmp_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .inv_trap_en(inv_trap_en),
  .cc(cc), .exc_now(exc_now), .trap(trap), .done(done)
);

// File: tb/test_fp_cmp_unit.sv
module test_fp_cmp_unit;
  logic        clk = 0, rst_n = 0, start = 0, dbl = 0, sig_cmp = 0, inv_trap_en = 0;
  logic [63:0] opa = '0, opb = '0;
  logic [1:0]  cc;
  logic [4:0]  exc_now;
  logic        trap, done;
  int          n_run = 0, n_fail = 0;
  logic [1:0]  model_cc = 2'd0;

  always #10 clk = ~clk;

  fp_cmp_unit i_fp_cmp_unit (.clk(clk), .rst_n(rst_n), .start(start), .dbl(dbl),
    .sig_cmp(sig_cmp), .inv_trap_en(inv_trap_en), .opa(opa), .opb(opb),
    .cc(cc), .exc_now(exc_now), .trap(trap), .done(done));

  function automatic logic [63:0] widen(input logic [63:0] x, input logic d);
    return d ? x : {x[31], 32'd0, x[30:0]};
  endfunction

  function automatic logic is_nan(input logic [63:0] x, input logic d);
    if (d) return x[62:52] == 11'h7FF && x[51:0] != 0;
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction

  function automatic logic is_snan(input logic [63:0] x, input logic d);
    return is_nan(x, d) && (d ? !x[51] : !x[22]);
  endfunction

  function automatic logic [63:0] okey(input logic [63:0] w);
    return w[63] ? ~w : (w ^ 64'h8000_0000_0000_0000);
  endfunction

  function automatic logic [1:0] ref_code(input logic [63:0] a, input logic [63:0] b, input logic d);
    logic [63:0] wa, wb;
    if (is_nan(a, d) || is_nan(b, d)) return 2'd3;
    wa = widen(a, d); wb = widen(b, d);
    if (wa[62:0] == 0 && wb[62:0] == 0) return 2'd0;
    if (okey(wa) == okey(wb)) return 2'd0;
    return okey(wa) < okey(wb) ? 2'd1 : 2'd2;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_cmp(input logic [63:0] a, input logic [63:0] b, input logic d,
                        input logic s, input logic te, input string req);
    logic [1:0] code;
    logic       inv;
    code = ref_code(a, b, d);
    inv  = is_snan(a, d) || is_snan(b, d) || (s && code == 2'd3);
    @(negedge clk);
    opa = a; opb = b; dbl = d; sig_cmp = s; inv_trap_en = te; start = 1;
    @(negedge clk);
    start = 0;
    if (!(inv && te)) model_cc = code;
    check(cc == model_cc, req, "cc", cc, model_cc);
    check(exc_now == {inv, 4'b0}, "R11", "exc_now", exc_now, {inv, 4'b0});
    check(trap == (inv && te), "R5", "trap", trap, inv && te);
    check(done == 1'b1, "R9", "done", done, 1);
    @(negedge clk);
    check(done == 0 && trap == 0 && cc == model_cc, "R9", "idle", {done, trap, cc}, {2'b00, model_cc});
  endtask

  function automatic logic [63:0] special(input int k, input logic d);
    case (k)
      0: return d ? 64'h7FF8_0000_0000_0000 : {32'hDEAD_BEEF, 32'h7FC0_0000};
      1: return d ? 64'h7FF0_0000_0000_0001 : {32'h1234_5678, 32'h7F80_0001};
      2: return d ? 64'hFFF0_0000_0000_0000 : {32'h0, 32'hFF80_0000};
      3: return d ? 64'h8000_0000_0000_0000 : {32'hFFFF_FFFF, 32'h8000_0000};
      4: return d ? 64'h0000_0000_0000_0001 : {32'h0, 32'h0000_0001};
      default: return d ? 64'h3FF0_0000_0000_0000 : {32'hA5A5_A5A5, 32'h3F80_0000};
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] a, b;
    logic d;
    void'($urandom(32'd1234));
    #35;
    check(cc == 0 && exc_now == 0 && trap == 0 && done == 0, "R10", "reset", {cc, exc_now, trap, done}, 0);
    rst_n = 1;
    do_cmp(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1, 0, 0, "R1 lt");
    do_cmp(64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 0, 0, "R1 gt");
    do_cmp(64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, 1, 0, 0, "R1 eq");
    do_cmp(64'h0, 64'h8000_0000_0000_0000, 1, 0, 0, "R6 dbl zeros");
    do_cmp(64'h8000_0000, 64'h0, 0, 0, 0, "R6 sgl zeros");
    do_cmp(64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1, 0, 0, "R7 inf");
    do_cmp(64'h0000_0000_0000_0001, 64'h0, 1, 0, 0, "R7 subnormal");
    do_cmp(64'h8000_0000_0000_0001, 64'h8000_0000_0000_0002, 1, 0, 0, "R7 neg subnormal");
    do_cmp({32'hFFFF_FFFF, 32'h3F80_0000}, {32'h0, 32'h3F80_0000}, 0, 0, 0, "R8 upper ignored");
    do_cmp({32'h0, 32'hBF80_0000}, {32'h7FF8_0000, 32'h3F80_0000}, 0, 0, 0, "R8 sgl lt");
    do_cmp(64'h7FF8_0000_0000_0000, 64'h0, 1, 0, 0, "R2 R3 qnan quiet");
    do_cmp(64'h0, 64'h7F80_0001, 0, 0, 0, "R3 snan quiet");
    do_cmp(64'h7FC0_0000, 64'h0, 0, 1, 0, "R4 qnan signalling");
    do_cmp(64'h3FF0_0000_0000_0000, 64'h0, 1, 0, 1, "R5 set gt");
    do_cmp(64'h7FF0_0000_0000_0001, 64'h0, 1, 0, 1, "R5 snan trap");
    do_cmp(64'h7FF8_0000_0000_0000, 64'h0, 1, 1, 1, "R5 qnan sig trap");
    do_cmp(64'h7FF8_0000_0000_0000, 64'h0, 1, 0, 1, "R3 qnan quiet no trap");
    for (int i = 0; i < 600; i++) begin
      d = 1'($urandom);
      a = {$urandom, $urandom};
      case ($urandom % 4)
        0: b = {$urandom, $urandom};
        1: begin a = special($urandom % 6, d); b = special($urandom % 6, d); end
        2: b = a;
        default: b = a ^ 64'($urandom % 4);
      endcase
      if ($urandom % 4 == 0) a = special($urandom % 6, d);
      do_cmp(a, b, d, 1'($urandom), 1'($urandom), "R1 R2 R3 R4 random");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule